// File: doc/BRIEF.md
# Programmable Interframe Gap Transmit Gate

This block sits between a transmit MAC's frame scheduler and its line driver. It holds the idle gap between two frames sent back to back. The gap length comes from a two-bit code. The gap is counted in bit times, so one rule, 84 + 4 × code bit times, gives 8.4 µs to 9.6 µs at 10 Mbps and 840 ns to 960 ns at 100 Mbps. Code 3 is the only value that meets the standard minimum gap. Codes 0 to 2 shorten the gap in even steps, which is useful for test and tuning work.

A requester raises `tx_req` and waits for `tx_grant`. The frame begins on the first clock where both are high and lasts until `tx_eof`. For each frame the block captures three settings when the frame begins and keeps them for the whole frame: the gap code, the loopback code and the CRC-suppress bit. While the frame runs, the block either drives the line or routes the frame back internally, and it tells the CRC stage whether to append a checksum.

The timing input `tick` is the 100 Mbps bit strobe, one pulse per 10 ns. At 100 Mbps every pulse is one bit time. At 10 Mbps the block counts pulses and takes every tenth one as a bit time.

Top module: `ifg_tx_gate`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `tx_grant` is 1 and `line_en`, `lpbk_en` and `crc_en` are 0. A request on the first cycle after reset is granted at once.
- R2: A frame begins on the clock edge where `tx_req` and `tx_grant` are both 1. From the next cycle the block is in a frame and `tx_grant` is 0. The frame ends on the edge where `tx_eof` is 1.
- R3: After the edge that ends a frame, `tx_grant` stays 0 until 84 + 4 × G bit times have passed, where G is the gap code captured for that frame. It rises on the cycle after the last of those bit times. A bit time that falls on the ending edge itself is not counted.
- R4: With `speed_fast` = 1, every cycle in which `tick` = 1 is one bit time, however the pulses are spaced.
- R5: With `speed_fast` = 0, every tenth `tick` pulse is one bit time. A pulse counter advances on each pulse and returns to zero at ten. The counter is held at zero while `speed_fast` = 1.
- R6: Loopback code 2'b11: during the frame `lpbk_en` is 1 and `line_en` is 0.
- R7: Loopback codes 2'b00, 2'b01 and 2'b10 mean normal operation: during the frame `line_en` is 1 and `lpbk_en` is 0.
- R8: CRC-suppress bit 0 makes `crc_en` 1 during the frame. A value of 1 keeps `crc_en` at 0. Outside a frame `crc_en` is 0.
- R9: The gap code, loopback code and CRC-suppress bit are captured when the frame begins. Changing them during the frame changes neither the outputs of that frame nor the length of the gap that follows it.
- R10: `tx_eof` outside a frame has no effect. `tx_req` while `tx_grant` is 0 starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 100 Mbps bit strobe, one-cycle pulses |
| speed_fast | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| gap_code | input | 2 | Gap select, captured at frame start |
| lpbk_code | input | 2 | 2'b11 = loopback, other codes = normal |
| crc_off | input | 1 | 1 = no CRC appended to the frame |
| tx_req | input | 1 | Frame request |
| tx_eof | input | 1 | End-of-frame strobe |
| tx_grant | output | 1 | Transmit may start |
| line_en | output | 1 | Drive the frame onto the line |
| lpbk_en | output | 1 | Route the frame to the internal return path |
| crc_en | output | 1 | Append CRC to the frame |

## Verification
The assertions assume that `tick` and `tx_eof` are synchronous to `clk` and that the end strobe matters only inside a frame. They do not assume that `tx_req` is held, or that the configuration inputs stay constant outside the capture edge. The stimulus goes beyond these assumptions on purpose in a few places: it changes the configuration inputs in the middle of a frame, asserts the end strobe while idle, and requests during the gap. In the random phase every input changes on every cycle, and the speed select is mostly held at 100 Mbps so that a gap can finish within the run.

// File: rtl/ifg_gate_pkg.sv
package ifg_gate_pkg;

    typedef enum logic [1:0] {
        LB_NORMAL = 2'b00,
        LB_RSVD_A = 2'b01,
        LB_RSVD_B = 2'b10,
        LB_LOOP   = 2'b11
    } lpbk_code_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic [1:0] gap_sel;
        logic       loop;
        logic       no_crc;
    } frame_cfg_t;

    function automatic logic is_loop(input logic [1:0] code);
        return lpbk_code_e'(code) == LB_LOOP;
    endfunction

    function automatic int unsigned gap_bits(input logic [1:0] sel,
                                             input int unsigned base,
                                             input int unsigned step);
        return base + step * int'(sel);
    endfunction

endpackage

// File: rtl/ifg_bit_strobe.sv
module ifg_bit_strobe #(
    parameter int unsigned DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic speed_fast,
    output logic bit_tick
);
    generate
        if (DIV <= 1) begin : g_nodiv
            assign bit_tick = tick;
        end else begin : g_div
            localparam int unsigned DW   = $clog2(DIV);
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            logic [DW-1:0] pulse_q;

            always_ff @(posedge clk) begin
                if (rst || speed_fast) begin
                    pulse_q <= '0;
                end else if (tick) begin
                    pulse_q <= (pulse_q == LAST) ? '0 : pulse_q + 1'b1;
                end
            end

            assign bit_tick = speed_fast ? tick : (tick && pulse_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ifg_gap_timer.sv
module ifg_gap_timer #(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          bit_tick,
    output logic          expired
);
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (bit_tick && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign expired = (left_q == '0);
endmodule

// File: rtl/ifg_frame_ctrl.sv
module ifg_frame_ctrl
    import ifg_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       eof,
    input  logic [1:0] gap_code,
    input  logic [1:0] lpbk_code,
    input  logic       crc_off,
    input  logic       gap_done,
    output logic       grant,
    output logic       busy,
    output logic       frame_end,
    output frame_cfg_t cfg
);
    gate_state_e state_q;
    frame_cfg_t  cfg_q;
    logic        start;

    assign grant     = (state_q == ST_IDLE) && gap_done;
    assign start     = grant && req;
    assign frame_end = (state_q == ST_FRAME) && eof;
    assign busy      = (state_q == ST_FRAME);
    assign cfg       = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
        end else if (start) begin
            state_q        <= ST_FRAME;
            cfg_q.gap_sel  <= gap_code;
            cfg_q.loop     <= is_loop(lpbk_code);
            cfg_q.no_crc   <= crc_off;
        end else if (frame_end) begin
            state_q <= ST_IDLE;
        end
    end
endmodule

// File: rtl/ifg_tx_gate.sv
module ifg_tx_gate
    import ifg_gate_pkg::*;
#(
    parameter int unsigned GAP_BASE  = 84,
    parameter int unsigned GAP_STEP  = 4,
    parameter int unsigned SLOW_DIV  = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       speed_fast,
    input  logic [1:0] gap_code,
    input  logic [1:0] lpbk_code,
    input  logic       crc_off,
    input  logic       tx_req,
    input  logic       tx_eof,
    output logic       tx_grant,
    output logic       line_en,
    output logic       lpbk_en,
    output logic       crc_en
);
    localparam int unsigned GAP_MAX = GAP_BASE + 3 * GAP_STEP;
    localparam int unsigned CW      = $clog2(GAP_MAX + 1);

    logic          bit_tick;
    logic          gap_done;
    logic          busy;
    logic          frame_end;
    frame_cfg_t    cfg;
    logic [CW-1:0] gap_len;

    assign gap_len = CW'(gap_bits(cfg.gap_sel, GAP_BASE, GAP_STEP));

    ifg_bit_strobe #(.DIV(SLOW_DIV)) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .speed_fast (speed_fast),
        .bit_tick   (bit_tick)
    );

    ifg_gap_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (frame_end),
        .load_val (gap_len),
        .bit_tick (bit_tick),
        .expired  (gap_done)
    );

    ifg_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (tx_req),
        .eof       (tx_eof),
        .gap_code  (gap_code),
        .lpbk_code (lpbk_code),
        .crc_off   (crc_off),
        .gap_done  (gap_done),
        .grant     (tx_grant),
        .busy      (busy),
        .frame_end (frame_end),
        .cfg       (cfg)
    );

    assign line_en = busy && !cfg.loop;
    assign lpbk_en = busy &&  cfg.loop;
    assign crc_en  = busy && !cfg.no_crc;
endmodule

// File: rtl/ifg_tx_gate_chk.sv
module ifg_tx_gate_chk (
    input logic clk,
    input logic rst,
    input logic tx_req,
    input logic tx_eof,
    input logic tx_grant,
    input logic line_en,
    input logic lpbk_en,
    input logic crc_en
);
    logic in_frame;
    assign in_frame = line_en || lpbk_en;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tx_grant && !line_en && !lpbk_en && !crc_en));

    a_r2_grant_only_idle: assert property (@(posedge clk) disable iff (rst)
        tx_grant |-> !in_frame && !crc_en);

    a_r2_start_enters_frame: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_grant) |=> in_frame);

    a_r3_gap_follows_end: assert property (@(posedge clk) disable iff (rst)
        (in_frame && tx_eof) |=> !tx_grant && !in_frame);

    a_r6_paths_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(line_en && lpbk_en));

    a_r9_cfg_held: assert property (@(posedge clk) disable iff (rst)
        (in_frame && !tx_eof) |=> ($stable(line_en) && $stable(lpbk_en) && $stable(crc_en)));

    a_r10_no_start_without_grant: assert property (@(posedge clk) disable iff (rst)
        (!in_frame && !(tx_req && tx_grant)) |=> !in_frame);
endmodule

bind ifg_tx_gate ifg_tx_gate_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_req   (tx_req),
    .tx_eof   (tx_eof),
    .tx_grant (tx_grant),
    .line_en  (line_en),
    .lpbk_en  (lpbk_en),
    .crc_en   (crc_en)
);

// File: tb/ifg_tx_gate_tb.sv
module ifg_tx_gate_tb;
    logic clk = 1'b0;
    logic rst, tick, speed_fast, crc_off, tx_req, tx_eof;
    logic [1:0] gap_code, lpbk_code;
    logic tx_grant, line_en, lpbk_en, crc_en;

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    int   m_busy, m_cnt, m_div, m_gap, m_loop, m_nocrc;

    always #5 clk = ~clk;

    ifg_tx_gate u_dut (
        .clk(clk), .rst(rst), .tick(tick), .speed_fast(speed_fast),
        .gap_code(gap_code), .lpbk_code(lpbk_code), .crc_off(crc_off),
        .tx_req(tx_req), .tx_eof(tx_eof), .tx_grant(tx_grant),
        .line_en(line_en), .lpbk_en(lpbk_en), .crc_en(crc_en)
    );

    function automatic int gap_of(input int code);
        return 84 + 4 * code;
    endfunction

    function automatic int exp_grant();
        return (m_busy == 0 && m_cnt == 0) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "tx_grant", int'(tx_grant), exp_grant());
        chk(tag, "line_en", int'(line_en), (m_busy != 0 && m_loop == 0) ? 1 : 0);
        chk(tag, "lpbk_en", int'(lpbk_en), (m_busy != 0 && m_loop != 0) ? 1 : 0);
        chk(tag, "crc_en", int'(crc_en), (m_busy != 0 && m_nocrc == 0) ? 1 : 0);
    endtask

    // drive one cycle at a negedge, advance the reference, check at next negedge
    task automatic step(input logic rq, input logic ef, input logic tk, input logic fs,
                        input logic [1:0] gs, input logic [1:0] lb, input logic nc,
                        input string tag);
        int bt;
        int ending;
        tx_req = rq; tx_eof = ef; tick = tk; speed_fast = fs;
        gap_code = gs; lpbk_code = lb; crc_off = nc;
        bt = fs ? int'(tk) : ((tk && m_div == 9) ? 1 : 0);
        if (fs) m_div = 0;
        else if (tk) m_div = (m_div == 9) ? 0 : m_div + 1;
        ending = (m_busy != 0 && ef) ? 1 : 0;
        if (m_busy == 0 && m_cnt == 0 && rq) begin
            m_busy = 1; m_gap = int'(gs); m_loop = (lb == 2'b11) ? 1 : 0; m_nocrc = int'(nc);
        end else if (ending != 0) begin
            m_busy = 0; m_cnt = gap_of(m_gap);
        end
        if (ending == 0 && bt != 0 && m_cnt != 0) m_cnt--;
        @(negedge clk);
        chk_all(tag);
    endtask

    task automatic wait_grant(input logic fs, input string tag);
        for (int i = 0; i < 3000 && !tx_grant; i++) step(0, 0, 1, fs, 0, 0, 0, tag);
    endtask

    // one frame: wait for grant, start, run len cycles without ticks, end
    task automatic frame(input logic fs, input logic [1:0] gs, input logic [1:0] lb,
                         input logic nc, input int len, input string tag);
        wait_grant(fs, tag);
        step(1, 0, 0, fs, gs, lb, nc, tag);
        for (int i = 0; i < len; i++) step(0, 0, 0, fs, gs, lb, nc, tag);
        step(0, 1, 0, fs, gs, lb, nc, tag);
    endtask

    task automatic measure(input logic fs, input int expect_pulses, input string tag);
        int k = 0;
        while (!tx_grant && k < 5000) begin
            step(0, 0, 1, fs, 0, 0, 0, tag);
            k++;
        end
        chk(tag, "gap pulses", k, expect_pulses);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst = 1; tick = 0; speed_fast = 1; crc_off = 0; tx_req = 0; tx_eof = 0;
        gap_code = 0; lpbk_code = 0;
        repeat (3) @(negedge clk);
        m_busy = 0; m_cnt = 0; m_div = 0; m_gap = 0; m_loop = 0; m_nocrc = 0;
        chk_all("R1");
        rst = 0;
        @(negedge clk);
        chk_all("R1");
        // first request after reset is granted immediately
        step(1, 0, 0, 1, 2'd3, 2'b00, 1'b0, "R1");
        chk("R1", "frame started", int'(line_en), 1);
        step(0, 0, 1, 1, 0, 0, 0, "R2");
        step(0, 1, 0, 1, 0, 0, 0, "R2");
        measure(1, gap_of(3), "R3");

        // every gap code at 100 Mbps with a pulse each cycle
        for (int g = 0; g < 4; g++) begin
            frame(1, 2'(g), 2'b00, 1'b0, 4, "R3");
            measure(1, gap_of(g), "R3");
        end

        // 100 Mbps, sparse pulses: bit times follow pulses
        frame(1, 2'd1, 2'b00, 1'b0, 2, "R4");
        for (int i = 0; i < 400 && !tx_grant; i++)
            step(0, 0, (i % 3) == 0, 1, 0, 0, 0, "R4");
        chk("R4", "granted after sparse ticks", int'(tx_grant), 1);

        // 10 Mbps: ten pulses per bit time
        frame(1, 2'd0, 2'b00, 1'b0, 3, "R5");
        measure(0, 10 * gap_of(0), "R5");
        frame(1, 2'd2, 2'b00, 1'b0, 3, "R5");
        measure(0, 10 * gap_of(2), "R5");

        // loopback and CRC options
        frame(1, 2'd0, 2'b11, 1'b0, 3, "R6");
        frame(1, 2'd0, 2'b11, 1'b1, 3, "R8");
        frame(1, 2'd0, 2'b01, 1'b1, 3, "R7");
        frame(1, 2'd0, 2'b10, 1'b0, 3, "R7");
        frame(1, 2'd0, 2'b00, 1'b1, 3, "R8");

        // configuration changes mid-frame have no effect
        wait_grant(1, "R9");
        step(1, 0, 0, 1, 2'd0, 2'b11, 1'b0, "R9");
        step(0, 0, 0, 1, 2'd3, 2'b00, 1'b1, "R9");
        chk("R9", "lpbk held", int'(lpbk_en), 1);
        chk("R9", "crc held", int'(crc_en), 1);
        step(0, 1, 0, 1, 2'd3, 2'b00, 1'b1, "R9");
        measure(1, gap_of(0), "R9");

        // end strobe while idle; request during the gap
        step(0, 1, 0, 1, 0, 0, 0, "R10");
        chk("R10", "still granted", int'(tx_grant), 1);
        frame(1, 2'd1, 2'b00, 1'b0, 2, "R10");
        for (int i = 0; i < 20; i++) step(1, 0, 1, 1, 0, 0, 0, "R10");
        chk("R10", "no frame during gap", int'(line_en | lpbk_en), 0);

        // constrained random
        for (int i = 0; i < 6000; i++) begin
            step(($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 2) == 0,
                 ($urandom % 16) != 0, 2'($urandom), 2'($urandom), 1'($urandom), "R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule